// File: doc/BRIEF.md
# Perceptron Classifier Sequencer

This block drives a fully connected two-layer perceptron that decides whether a small greyscale image shows a face. It has no arithmetic of its own apart from counters and address generation. A single pipelined floating-point multiplier and a single pipelined floating-point adder sit outside the block, and every product, sum, activation and comparison is issued to them. For each hidden neuron the sequencer streams pixel/weight pairs out of two external memories, one pair per cycle. It accumulates the products, scales the total by a linear activation and parks the result in a local hidden-value store. It then runs the single output neuron over the stored hidden values, scales that total as well, and subtracts a programmable threshold. The sign of the difference gives the verdict.

The adder has a latency of several cycles. A running total is therefore never fed straight back into it. Instead, each new product is added to whichever partial sum is leaving the adder pipeline in that cycle, so `ADD_LAT` partial sums circulate at once. When a neuron's stream ends, those partials are captured and folded into one total by a short chain of dependent additions.

The states are IDLE, HID_MAC, HID_FOLD, HID_ACT, OUT_MAC, OUT_FOLD, OUT_ACT, DECIDE and DONE. The transitions are:
- IDLE goes to HID_MAC on `start`.
- Each MAC state goes to its FOLD state once all partial sums have been captured. It goes straight to its ACT state when `ADD_LAT` is 1.
- Each FOLD state goes to its ACT state after the last fold addition returns.
- HID_ACT returns to HID_MAC for the next hidden neuron, or goes to OUT_MAC after the last one.
- OUT_ACT goes to DECIDE.
- DECIDE goes to DONE when the difference returns.
- DONE goes back to IDLE.

`N_IN` and `N_HID` must each be at least `ADD_LAT`.

Top module: `nnc_classifier_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done`, `face`, `px_rd`, `wt_rd`, `mul_go` and `add_go` are all 0.
- R2: For hidden neuron j (0 to N_HID-1) the block reads pixel address i together with weight address j*N_IN+i, for i from 0 to N_IN-1 in ascending order, one pair per cycle. Read data is expected on the cycle after the address.
- R3: The output neuron reads weight addresses N_HID*N_IN+j for j from 0 to N_HID-1 in ascending order, paired with stored hidden value j. No pixel is read outside the hidden layer.
- R4: Each neuron total is multiplied once by `ACT_SCALE` (default 0x3F400000, which is 0.75 in single precision). A frame issues exactly N_HID*N_IN + 2*N_HID + 1 multiplies.
- R5: The verdict comes from one adder issue with `add_sub`=1, a = network output and b = `thresh`. `face` is 1 when bit 31 of the result is 0, which includes an exact tie, and 0 otherwise.
- R6: `done` is high for exactly one cycle per frame, and `face` is valid in that cycle. `face` keeps its value until the next verdict.
- R7: A `start` that arrives outside IDLE has no effect. No extra reads take place, there is no second `done`, and the frame's result is unchanged.
- R8: No partial sum re-enters the adder before its previous addition has left the pipeline. Each total equals the exact sum of its products, and a frame issues N_HID*N_IN + N_HID + (N_HID+1)*(ADD_LAT-1) + 1 additions.
- R9: An operand pair presented with `mul_go` or `add_go` in cycle t is consumed from `mul_y`/`add_y` in cycle t+MUL_LAT or t+ADD_LAT respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (only acted on in IDLE) |
| thresh | input | 32 | Decision threshold |
| px_rd | output | 1 | Pixel memory read strobe |
| px_addr | output | PA | Pixel address |
| px_rdata | input | 32 | Pixel data, one cycle after address |
| wt_rd | output | 1 | Weight memory read strobe |
| wt_addr | output | WA | Weight address |
| wt_rdata | input | 32 | Weight data, one cycle after address |
| mul_go | output | 1 | Multiplier issue strobe |
| mul_a | output | 32 | Multiplier operand a |
| mul_b | output | 32 | Multiplier operand b |
| mul_y | input | 32 | Multiplier result, MUL_LAT cycles after issue |
| add_go | output | 1 | Adder issue strobe |
| add_sub | output | 1 | 1 requests a - b, 0 requests a + b |
| add_a | output | 32 | Adder operand a |
| add_b | output | 32 | Adder operand b |
| add_y | input | 32 | Adder result, ADD_LAT cycles after issue |
| done | output | 1 | One-cycle frame-complete pulse |
| face | output | 1 | Verdict, 1 = face |

## Verification
The bench keeps queues of the addresses each memory must see and pops one entry on every cycle a read strobe is high. The address is compared in that same cycle, so ordering errors and stray reads surface immediately rather than at the end of the frame.

The external units are modelled with exactly `MUL_LAT` and `ADD_LAT` stages. A correct total therefore proves that the block consumed every result in the cycle it was due. The verdict is compared in the single `done` cycle, which follows the cycle in which the threshold difference returns from the adder. A settling window after each frame confirms that no second pulse or extra read appears and that `face` holds.

// File: rtl/nnc_pkg.sv
`timescale 1ns/1ps
package nnc_pkg;
    localparam int unsigned WORD = 32;
    typedef logic [WORD-1:0] word_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HID_MAC,
        S_HID_FOLD,
        S_HID_ACT,
        S_OUT_MAC,
        S_OUT_FOLD,
        S_OUT_ACT,
        S_DECIDE,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/nnc_lat_track.sv
`timescale 1ns/1ps
module nnc_lat_track #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic emerge,
    output logic idle
);
    logic [DEPTH-1:0] vld;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld <= '0;
                else        vld <= issue;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) vld <= '0;
                else        vld <= {vld[DEPTH-2:0], issue};
            end
        end
    endgenerate

    assign emerge = vld[DEPTH-1];
    assign idle   = (vld == '0);
endmodule

// File: rtl/nnc_hid_store.sv
`timescale 1ns/1ps
module nnc_hid_store
    import nnc_pkg::*;
#(
    parameter int unsigned DEPTH = 300,
    parameter int unsigned AW    = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/nnc_classifier_seq.sv
`timescale 1ns/1ps
module nnc_classifier_seq
    import nnc_pkg::*;
#(
    parameter int unsigned N_IN      = 400,
    parameter int unsigned N_HID     = 300,
    parameter int unsigned MUL_LAT   = 2,
    parameter int unsigned ADD_LAT   = 5,
    parameter logic [31:0] ACT_SCALE = 32'h3F40_0000,
    localparam int unsigned PA = $clog2(N_IN),
    localparam int unsigned WA = $clog2(N_IN*N_HID + N_HID)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   thresh,
    output logic          px_rd,
    output logic [PA-1:0] px_addr,
    input  logic [31:0]   px_rdata,
    output logic          wt_rd,
    output logic [WA-1:0] wt_addr,
    input  logic [31:0]   wt_rdata,
    output logic          mul_go,
    output logic [31:0]   mul_a,
    output logic [31:0]   mul_b,
    input  logic [31:0]   mul_y,
    output logic          add_go,
    output logic          add_sub,
    output logic [31:0]   add_a,
    output logic [31:0]   add_b,
    input  logic [31:0]   add_y,
    output logic          done,
    output logic          face
);
    localparam int unsigned FAN_MAX = (N_IN > N_HID) ? N_IN : N_HID;
    localparam int unsigned KW = $clog2(FAN_MAX + 1);
    localparam int unsigned JW = $clog2(N_HID + 1);
    localparam int unsigned HA = (N_HID > 1) ? $clog2(N_HID) : 1;
    localparam int unsigned LW = $clog2(ADD_LAT + 1);
    localparam logic [KW-1:0] K_IN   = KW'(N_IN);
    localparam logic [KW-1:0] K_HID  = KW'(N_HID);
    localparam logic [JW-1:0] J_LAST = JW'(N_HID - 1);
    localparam logic [LW-1:0] L_LAST = LW'(ADD_LAT - 1);

    seq_state_e state_q, state_d;
    logic [KW-1:0] k_q;
    logic [JW-1:0] j_q;
    logic [WA-1:0] wbase_q;
    logic [LW-1:0] pcnt_q, f_q;
    logic          rdv_q, fbusy_q, issued_q, face_q;
    word_t         acc_q, outv_q, hb_q;
    word_t         part_q [ADD_LAT];

    logic in_mac, out_layer, in_fold, rd_now, cap, cap_last;
    logic m_emerge, m_idle, a_emerge, a_idle, hb_we;
    logic [KW-1:0] fan;

    // ---------------- helpers ----------------
    assign in_mac    = (state_q == S_HID_MAC) || (state_q == S_OUT_MAC);
    assign in_fold   = (state_q == S_HID_FOLD) || (state_q == S_OUT_FOLD);
    assign out_layer = (state_q == S_OUT_MAC);
    assign fan       = out_layer ? K_HID : K_IN;
    assign rd_now    = in_mac && (k_q < fan);
    assign cap       = in_mac && a_emerge && !m_emerge;
    assign cap_last  = cap && (pcnt_q == L_LAST);
    assign hb_we     = (state_q == S_HID_ACT) && m_emerge;

    assign px_rd   = rd_now && (state_q == S_HID_MAC);
    assign px_addr = PA'(k_q);
    assign wt_rd   = rd_now;
    assign wt_addr = wbase_q + WA'(k_q);
    assign done    = (state_q == S_DONE);
    assign face    = face_q;

    nnc_lat_track #(.DEPTH(MUL_LAT)) u_mul_trk (
        .clk(clk), .rst_n(rst_n), .issue(mul_go), .emerge(m_emerge), .idle(m_idle));
    nnc_lat_track #(.DEPTH(ADD_LAT)) u_add_trk (
        .clk(clk), .rst_n(rst_n), .issue(add_go), .emerge(a_emerge), .idle(a_idle));
    nnc_hid_store #(.DEPTH(N_HID), .AW(HA)) u_hstore (
        .clk(clk), .we(hb_we), .waddr(HA'(j_q)), .wdata(mul_y),
        .raddr(HA'(k_q)), .rdata(hb_q));

    // ---------------- operand issue ----------------
    always_comb begin
        mul_go = 1'b0;
        mul_a  = '0;
        mul_b  = '0;
        if (in_mac && rdv_q) begin
            mul_go = 1'b1;
            mul_a  = out_layer ? hb_q : px_rdata;
            mul_b  = wt_rdata;
        end else if ((state_q == S_HID_ACT || state_q == S_OUT_ACT) && !issued_q) begin
            mul_go = 1'b1;
            mul_a  = acc_q;
            mul_b  = ACT_SCALE;
        end
    end

    always_comb begin
        add_go  = 1'b0;
        add_sub = 1'b0;
        add_a   = '0;
        add_b   = '0;
        if (in_mac && m_emerge) begin
            add_go = 1'b1;
            add_a  = mul_y;
            add_b  = a_emerge ? add_y : '0;
        end else if (in_fold && !fbusy_q) begin
            add_go = 1'b1;
            add_a  = acc_q;
            add_b  = part_q[f_q];
        end else if (state_q == S_DECIDE && !issued_q) begin
            add_go  = 1'b1;
            add_sub = 1'b1;
            add_a   = outv_q;
            add_b   = thresh;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_HID_MAC;
            S_HID_MAC:  if (cap_last) state_d = (ADD_LAT == 1) ? S_HID_ACT : S_HID_FOLD;
            S_HID_FOLD: if (a_emerge && f_q == L_LAST) state_d = S_HID_ACT;
            S_HID_ACT:  if (m_emerge) state_d = (j_q == J_LAST) ? S_OUT_MAC : S_HID_MAC;
            S_OUT_MAC:  if (cap_last) state_d = (ADD_LAT == 1) ? S_OUT_ACT : S_OUT_FOLD;
            S_OUT_FOLD: if (a_emerge && f_q == L_LAST) state_d = S_OUT_ACT;
            S_OUT_ACT:  if (m_emerge) state_d = S_DECIDE;
            S_DECIDE:   if (a_emerge) state_d = S_DONE;
            S_DONE:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q <= '0; j_q <= '0; wbase_q <= '0; pcnt_q <= '0; f_q <= '0;
            rdv_q <= 1'b0; fbusy_q <= 1'b0; issued_q <= 1'b0; face_q <= 1'b0;
            acc_q <= '0; outv_q <= '0;
            for (int i = 0; i < ADD_LAT; i++) part_q[i] <= '0;
        end else begin
            rdv_q <= rd_now;
            if (rd_now) k_q <= k_q + 1'b1;
            unique case (state_q)
                S_IDLE: if (start) begin
                    k_q <= '0; j_q <= '0; wbase_q <= '0; pcnt_q <= '0;
                end
                S_HID_MAC, S_OUT_MAC: if (cap) begin
                    part_q[0] <= add_y;
                    for (int i = 1; i < ADD_LAT; i++) part_q[i] <= part_q[i-1];
                    pcnt_q <= pcnt_q + 1'b1;
                    if (cap_last) begin
                        acc_q    <= add_y;
                        f_q      <= LW'(1);
                        fbusy_q  <= 1'b0;
                        pcnt_q   <= '0;
                        issued_q <= 1'b0;
                    end
                end
                S_HID_FOLD, S_OUT_FOLD: begin
                    if (add_go) fbusy_q <= 1'b1;
                    if (a_emerge) begin
                        acc_q   <= add_y;
                        fbusy_q <= 1'b0;
                        f_q     <= f_q + 1'b1;
                    end
                end
                S_HID_ACT: begin
                    if (mul_go) issued_q <= 1'b1;
                    if (m_emerge) begin
                        j_q      <= j_q + 1'b1;
                        wbase_q  <= wbase_q + WA'(N_IN);
                        k_q      <= '0;
                        issued_q <= 1'b0;
                    end
                end
                S_OUT_ACT: begin
                    if (mul_go) issued_q <= 1'b1;
                    if (m_emerge) begin
                        outv_q   <= mul_y;
                        issued_q <= 1'b0;
                    end
                end
                S_DECIDE: begin
                    if (add_go) issued_q <= 1'b1;
                    if (a_emerge) begin
                        face_q   <= ~add_y[31];
                        issued_q <= 1'b0;
                    end
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_FACE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_DECIDE) |=> $stable(face)); // R6
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> (j_q >= $past(j_q))); // R7
    AST_FOLD_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fold && add_go) |-> a_idle); // R8
    AST_ACT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && (state_q == S_HID_ACT || state_q == S_OUT_ACT)) |=> !mul_go); // R4
    AST_ACT_PIPE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go && (state_q == S_HID_ACT || state_q == S_OUT_ACT)) |-> m_idle); // R9
    AST_PX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        px_rd |-> (int'(px_addr) < N_IN)); // R2
    AST_WT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wt_rd |-> (int'(wt_addr) < N_IN*N_HID + N_HID)); // R3
endmodule

// File: tb/nnc_classifier_seq_bench.sv
`timescale 1ns/1ps
module nnc_classifier_seq_bench;
    localparam int NI = 6;
    localparam int NH = 4;
    localparam int ML = 2;
    localparam int AL = 3;
    localparam logic [31:0] SC = 32'd3;
    localparam int PA = $clog2(NI);
    localparam int WA = $clog2(NI*NH + NH);
    localparam int WDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] thresh = '0;
    logic px_rd, wt_rd, mul_go, add_go, add_sub, done, face;
    logic [PA-1:0] px_addr;
    logic [WA-1:0] wt_addr;
    logic [31:0] px_rdata, wt_rdata, mul_a, mul_b, mul_y, add_a, add_b, add_y;

    nnc_classifier_seq #(.N_IN(NI), .N_HID(NH), .MUL_LAT(ML), .ADD_LAT(AL), .ACT_SCALE(SC))
    u_nnc_classifier_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .thresh(thresh),
        .px_rd(px_rd), .px_addr(px_addr), .px_rdata(px_rdata),
        .wt_rd(wt_rd), .wt_addr(wt_addr), .wt_rdata(wt_rdata),
        .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b), .mul_y(mul_y),
        .add_go(add_go), .add_sub(add_sub), .add_a(add_a), .add_b(add_b), .add_y(add_y),
        .done(done), .face(face));

    always #2 clk = ~clk;

    // external memories: one-cycle read latency
    logic [31:0] px_mem [1<<PA];
    logic [31:0] wt_mem [1<<WA];
    always @(posedge clk) begin
        px_rdata <= px_mem[px_addr];
        wt_rdata <= wt_mem[wt_addr];
    end

    // external arithmetic units: integer stand-ins with fixed latency
    logic [31:0] mpipe [ML];
    logic [31:0] apipe [AL];
    always @(posedge clk) begin
        mpipe[0] <= mul_a * mul_b;
        for (int i = 1; i < ML; i++) mpipe[i] <= mpipe[i-1];
        apipe[0] <= add_sub ? (add_a - add_b) : (add_a + add_b);
        for (int i = 1; i < AL; i++) apipe[i] <= apipe[i-1];
    end
    assign mul_y = mpipe[ML-1];
    assign add_y = apipe[AL-1];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_done, mul_cnt, add_cnt, mon_e;
    int wq[$];
    int pq[$];
    logic exp_face;
    bit mon_on = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle reference comparison
    always @(negedge clk) begin
        if (mon_on) begin
            if (wt_rd) begin
                if (wq.size() == 0) check(1'b0, "R7", "stray weight read", wt_addr, -1);
                else begin
                    mon_e = wq.pop_front();
                    check(int'(wt_addr) == mon_e, (mon_e < NI*NH) ? "R2" : "R3",
                          "weight address", wt_addr, mon_e);
                end
            end
            if (px_rd) begin
                if (pq.size() == 0) check(1'b0, "R3", "pixel read outside hidden layer", px_addr, -1);
                else begin
                    mon_e = pq.pop_front();
                    check(int'(px_addr) == mon_e, "R2", "pixel address", px_addr, mon_e);
                end
            end
            if (mul_go) mul_cnt++;
            if (add_go) add_cnt++;
            if (done) begin
                n_done++;
                check(face == exp_face, "R5", "verdict at done", face, exp_face);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            errors++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_frame(input int pat, input int mode, input bit poke);
        logic [31:0] acc, outv, thr, diff;
        logic [31:0] h [NH];
        int t;
        for (int a = 0; a < (1<<WA); a++) wt_mem[a] = 32'(((a*5 + pat*7) % 9) - 4);
        for (int i = 0; i < (1<<PA); i++) px_mem[i] = 32'(((i*3 + pat*5) % 11) - 5);
        wq.delete();
        pq.delete();
        for (int j = 0; j < NH; j++) begin
            acc = '0;
            for (int i = 0; i < NI; i++) begin
                acc = acc + px_mem[i] * wt_mem[j*NI + i];
                wq.push_back(j*NI + i);
                pq.push_back(i);
            end
            h[j] = SC * acc;
        end
        acc = '0;
        for (int j = 0; j < NH; j++) begin
            acc = acc + h[j] * wt_mem[NH*NI + j];
            wq.push_back(NH*NI + j);
        end
        outv = SC * acc;
        case (mode)
            0: thr = outv;
            1: thr = outv + 32'd1;
            2: thr = outv - 32'd1;
            default: thr = ~outv;
        endcase
        diff = outv - thr;
        exp_face = ~diff[31];
        thresh = thr;
        mul_cnt = 0; add_cnt = 0; n_done = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (poke) begin
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R6", "frame completes", t, 5000);
        repeat (40) @(negedge clk);
        check(n_done == 1, poke ? "R7" : "R6", "done pulses per frame", n_done, 1);
        check(wq.size() == 0, "R2", "weight reads left over", wq.size(), 0);
        check(pq.size() == 0, "R2", "pixel reads left over", pq.size(), 0);
        check(mul_cnt == NH*NI + 2*NH + 1, "R4", "multiply issues", mul_cnt, NH*NI + 2*NH + 1);
        check(add_cnt == NH*NI + NH + (NH+1)*(AL-1) + 1, "R8", "add issues",
              add_cnt, NH*NI + NH + (NH+1)*(AL-1) + 1);
        check(face == exp_face, "R6", "verdict held after done", face, exp_face);
        check(done == 1'b0, "R6", "done low after frame", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, while held and right after release
        check(done == 1'b0 && face == 1'b0, "R1", "outputs in reset", {done, face}, 0);
        check(px_rd == 1'b0 && wt_rd == 1'b0, "R1", "reads in reset", {px_rd, wt_rd}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && face == 1'b0, "R1", "outputs after reset", {done, face}, 0);
        check(mul_go == 1'b0 && add_go == 1'b0, "R1", "issues after reset", {mul_go, add_go}, 0);
        mon_on = 1'b1;
        run_frame(0, 0, 1'b0);   // tie -> face (R5)
        run_frame(1, 1, 1'b1);   // just above -> non-face, mid-frame start (R7)
        run_frame(2, 2, 1'b0);   // just below -> face
        run_frame(3, 3, 1'b0);   // far threshold, R8 sums and R9 timing
        run_frame(4, 1, 1'b0);
        run_frame(5, 0, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule